// File: doc/BRIEF.md
# Ticket-Ordered Lock Manager

This block arbitrates a single shared resource among a fixed number of clients and grants it strictly in the order the requests arrived. It keeps two modular counters. The first hands out tickets. The second names the ticket currently being served. A client that asks for the lock is handed the dispenser's present value, and the dispenser steps forward. The client then waits until the serving counter reaches its ticket. A release from the holder steps the serving counter, and this passes the lock to the next ticket in line.

Each client has one request pulse input and one release pulse input. It sees a single grant line that stays high while it owns the resource. Requests that arrive in the same cycle are placed in line in ascending client index. The ticket width is chosen so that the number of outstanding tickets can never reach the counter range, so comparing a stored ticket with the serving counter modulo the width is always exact. A release from a client that does not hold the lock is dropped and reported on an error output.

Top module: `ticket_lock`

## Requirements
- R1: After a synchronous active-low reset, every grant bit and `rel_err` are low, and both counters start at zero, so the first client to request gets ticket zero.
- R2: A request from an idle client, sampled at a clock edge, gives that client the dispenser's current ticket and advances the dispenser by one at that same edge.
- R3: When several idle clients request at the same edge, they receive consecutive tickets with lower client index first, so their grants follow in ascending index order.
- R4: A waiting client's grant rises at the clock edge after the serving counter first equals its ticket. For a request made while no client holds or waits, this is the second edge counting the edge that samples the request.
- R5: No more than one grant bit is high in any cycle.
- R6: A grant stays high until its holder asserts release. The release lowers that grant and advances the serving counter at the same edge, and the next waiting client is granted at the following edge.
- R7: A release from a client whose grant is low changes no grant and does not move the serving counter. `rel_err` is high in the cycle after every edge at which any such release was sampled, and low otherwise.
- R8: A request from a client that already waits or holds is dropped and consumes no ticket. This is also the case when that client releases at the same edge.
- R9: Both counters wrap modulo 2^TKT_W. Arrival-order service stays correct over any number of wraps, because TKT_W is at least clog2(N_CLIENTS)+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_CLIENTS | Lock request pulse, one bit per client |
| rel | input | N_CLIENTS | Lock release pulse, one bit per client |
| grant | output | N_CLIENTS | Lock ownership, one bit per client, at most one high |
| rel_err | output | 1 | Registered flag: a release came from a non-holder at the previous edge |

## Verification
A corrupted stored ticket or a serving counter that skips or stalls shows up at the grant port within a single handoff. Depending on the fault, the grant goes to the wrong client, goes to two clients, or never rises, and the second case trips the one-hot check at once. A dispenser that counts a dropped request, or that orders simultaneous requests wrongly, leaves a ticket that no client owns or swaps two clients. The lock then stalls or serves clients out of order, and this becomes visible at the next release. Random traffic runs the counters through many wraps, so a fault that appears only at the wrap boundary also reaches the grant outputs.

// File: rtl/ticket_lock_pkg.sv
// Shared types for the ticket-ordered lock manager.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable constructs.
package ticket_lock_pkg;

    // Per-client state: idle, holding a ticket in line, or owning the lock.
    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_HOLD = 2'd2
    } slot_state_t;

endpackage

// File: rtl/tl_dispenser.sv
// Ticket dispenser. It hands consecutive tickets to the clients that are
// accepted at one edge, lowest index first, and advances by the number of
// tickets handed out. The counter wraps modulo 2^TKT_W.
// Assumes: take[i] is already qualified, meaning the client is idle.
module tl_dispenser #(
    parameter int N_CLIENTS = 4,
    parameter int TKT_W     = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_CLIENTS-1:0]            take,
    output logic [TKT_W-1:0]                next_tkt,
    output logic [N_CLIENTS-1:0][TKT_W-1:0] tkt_for
);

    logic [TKT_W-1:0] next_d;

    // Prefix-count the accepted requests to hand out ordered tickets.
    always_comb begin
        logic [TKT_W-1:0] acc;
        acc = next_tkt;
        for (int i = 0; i < N_CLIENTS; i++) begin
            tkt_for[i] = acc;
            if (take[i]) begin
                acc = acc + TKT_W'(1);
            end
        end
        next_d = acc;
    end

    // Hold the next ticket to hand out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_tkt <= '0;
        end else begin
            next_tkt <= next_d;
        end
    end

endmodule

// File: rtl/tl_serving.sv
// Now-serving counter. It advances by one on each valid release and wraps
// modulo 2^TKT_W.
// Assumes: advance is high for at most one release per cycle.
module tl_serving #(
    parameter int TKT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [TKT_W-1:0] serve
);

    // Step the serving ticket when the holder lets go.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serve <= '0;
        end else if (advance) begin
            serve <= serve + TKT_W'(1);
        end
    end

endmodule

// File: rtl/tl_slot.sv
// One client slot. It stores the client's ticket while the client waits and
// moves to the holding state one edge after the serving counter equals that
// ticket. Equality modulo 2^TKT_W is exact because live tickets never span
// the full range.
// Assumes: tkt_in is valid in any cycle where take is high.
module tl_slot
    import ticket_lock_pkg::*;
#(
    parameter int TKT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             rel,
    input  logic [TKT_W-1:0] serve,
    input  logic [TKT_W-1:0] tkt_in,
    output logic             take,
    output logic             grant,
    output logic             rel_ok,
    output logic             rel_bad
);

    slot_state_t      state;
    logic [TKT_W-1:0] my_tkt;
    logic             my_turn;

    // Decode the accepted request, the ownership and the release validity.
    always_comb begin
        my_turn = (my_tkt == serve);
        take    = req && (state == SLOT_IDLE);
        grant   = (state == SLOT_HOLD);
        rel_ok  = rel && grant;
        rel_bad = rel && !grant;
    end

    // Walk idle -> wait -> hold -> idle and capture the ticket on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SLOT_IDLE;
            my_tkt <= '0;
        end else begin
            case (state)
                SLOT_IDLE: if (req) begin
                    state  <= SLOT_WAIT;
                    my_tkt <= tkt_in;
                end
                SLOT_WAIT: if (my_turn) begin
                    state <= SLOT_HOLD;
                end
                SLOT_HOLD: if (rel) begin
                    state <= SLOT_IDLE;
                end
                default: state <= SLOT_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ticket_lock.sv
// Ticket-ordered lock manager. It serves N_CLIENTS clients first come,
// first served, using one ticket dispenser, one serving counter and one
// slot per client. Releases from non-holders are flagged on rel_err.
// Assumes: TKT_W >= clog2(N_CLIENTS)+1, and inputs are synchronous to clk.
module ticket_lock #(
    parameter int N_CLIENTS = 4,
    parameter int TKT_W     = $clog2(N_CLIENTS) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_CLIENTS-1:0] req,
    input  logic [N_CLIENTS-1:0] rel,
    output logic [N_CLIENTS-1:0] grant,
    output logic                 rel_err
);

    logic [N_CLIENTS-1:0]            take;
    logic [N_CLIENTS-1:0]            rel_ok;
    logic [N_CLIENTS-1:0]            rel_bad;
    logic [N_CLIENTS-1:0][TKT_W-1:0] tkt_for;
    logic [TKT_W-1:0]                next_tkt;
    logic [TKT_W-1:0]                serve;

    tl_dispenser #(.N_CLIENTS(N_CLIENTS), .TKT_W(TKT_W)) disp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .next_tkt (next_tkt),
        .tkt_for  (tkt_for)
    );

    tl_serving #(.TKT_W(TKT_W)) serv_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (|rel_ok),
        .serve   (serve)
    );

    for (genvar g = 0; g < N_CLIENTS; g++) begin : g_slot
        tl_slot #(.TKT_W(TKT_W)) slot_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req[g]),
            .rel     (rel[g]),
            .serve   (serve),
            .tkt_in  (tkt_for[g]),
            .take    (take[g]),
            .grant   (grant[g]),
            .rel_ok  (rel_ok[g]),
            .rel_bad (rel_bad[g])
        );
    end

    // Register the misuse flag for any release that came from a non-holder.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_err <= 1'b0;
        end else begin
            rel_err <= |rel_bad;
        end
    end

endmodule

// File: rtl/ticket_lock_chk.sv
// Property checker for ticket_lock, attached to it with bind.
module ticket_lock_chk #(
    parameter int N_CLIENTS = 4,
    parameter int TKT_W     = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [N_CLIENTS-1:0] req,
    input logic [N_CLIENTS-1:0] rel,
    input logic [N_CLIENTS-1:0] grant,
    input logic                 rel_err,
    input logic [N_CLIENTS-1:0] take,
    input logic [TKT_W-1:0]     next_tkt,
    input logic [TKT_W-1:0]     serve
);

    // R5
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2
    tkt_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> next_tkt == TKT_W'($past(next_tkt) + $countones($past(take))));

    // R6
    serve_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(rel & grant) |=> serve == TKT_W'($past(serve) + 1));

    // R7
    serve_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(rel & grant)) |=> $stable(serve));

    // R7
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(rel & ~grant) |=> rel_err);

    // R7
    err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(rel & ~grant)) |=> !rel_err);

    for (genvar g = 0; g < N_CLIENTS; g++) begin : g_per
        // R6
        grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[g] && !rel[g] |=> grant[g]);

        // R6
        grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grant[g] && rel[g] |=> !grant[g]);

        // R8
        drop_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
            req[g] && grant[g] |-> !take[g]);
    end

endmodule

bind ticket_lock ticket_lock_chk #(.N_CLIENTS(N_CLIENTS), .TKT_W(TKT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .rel      (rel),
    .grant    (grant),
    .rel_err  (rel_err),
    .take     (take),
    .next_tkt (next_tkt),
    .serve    (serve)
);

// File: tb/ticket_lock_test.sv
module ticket_lock_test;

    localparam int N     = 4;
    localparam int TW    = $clog2(N) + 1;
    localparam int RANGE = 1 << TW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] rel = '0;
    logic [N-1:0] grant;
    logic         rel_err;

    int checks = 0;
    int errors = 0;

    // Reference model: arrival queue, holder, busy flags.
    int     q[$];
    int     holder = -1;
    bit     busy[N];
    logic   m_err = 1'b0;
    int     handoffs = 0;

    always #2.5 clk = ~clk;

    ticket_lock #(.N_CLIENTS(N), .TKT_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .rel(rel),
        .grant(grant), .rel_err(rel_err)
    );

    function automatic logic [N-1:0] exp_grant(int h);
        return (h >= 0) ? (N'(1) << h) : '0;
    endfunction

    // Update the reference model from the inputs sampled at each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            holder = -1;
            m_err  = 1'b0;
            for (int i = 0; i < N; i++) busy[i] = 1'b0;
        end else begin
            int           pre_h;
            bit           pre_busy[N];
            pre_h = holder;
            for (int i = 0; i < N; i++) pre_busy[i] = busy[i];
            m_err = |(rel & ~exp_grant(pre_h));
            if (pre_h >= 0 && rel[pre_h]) begin
                holder = -1;
                busy[pre_h] = 1'b0;
                handoffs++;
            end
            if (pre_h < 0 && q.size() > 0) holder = q.pop_front();
            for (int i = 0; i < N; i++) begin
                if (req[i] && !pre_busy[i]) begin
                    q.push_back(i);
                    busy[i] = 1'b1;
                end
            end
        end
    end

    task automatic check_out(string tag);
        checks++;
        if (grant !== exp_grant(holder)) begin
            errors++;
            $display("FAIL %s grant actual %b expected %b", tag, grant, exp_grant(holder));
        end
        checks++;
        if (rel_err !== m_err) begin
            errors++;
            $display("FAIL %s rel_err actual %b expected %b", tag, rel_err, m_err);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, then check after the next edge.
    task automatic cyc(logic [N-1:0] r, logic [N-1:0] l, string tag);
        req = r;
        rel = l;
        @(posedge clk);
        @(negedge clk);
        req = '0;
        rel = '0;
        check_out(tag);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4129);
        repeat (4) @(negedge clk);
        check_out("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R1 idle");

        // Directed: lone request latency (R2, R4).
        cyc(4'b0001, '0, "R2 request");
        checks++;
        if (grant !== 4'b0000) begin
            errors++;
            $display("FAIL R4 early grant actual %b expected 0000", grant);
        end
        cyc('0, '0, "R4 grant");
        checks++;
        if (grant !== 4'b0001) begin
            errors++;
            $display("FAIL R4 grant actual %b expected 0001", grant);
        end
        // Simultaneous requests plus a repeat from the holder (R3, R8).
        cyc(4'b1111, '0, "R3 R8 simultaneous");
        cyc(4'b1111, '0, "R8 repeat");
        // Release from a non-holder (R7).
        cyc('0, 4'b0100, "R7 bad release");
        cyc('0, '0, "R7 after");
        // Hand the lock through the line (R6), holder re-requests on release (R8).
        for (int k = 0; k < 4; k++) begin
            cyc(exp_grant(holder), exp_grant(holder), "R6 R8 release");
            cyc('0, '0, "R6 handoff");
            cyc('0, '0, "R3 order");
        end

        // Constrained random traffic with many counter wraps (R5, R9).
        for (int k = 0; k < 4000; k++) begin
            logic [N-1:0] r;
            logic [N-1:0] l;
            r = ($urandom % 3 == 0) ? N'($urandom) : '0;
            l = '0;
            if (holder >= 0 && $urandom % 3 == 0) l = exp_grant(holder);
            if ($urandom % 16 == 0) l = l | N'($urandom);
            cyc(r, l, "R5 R9 random");
        end

        checks++;
        if (handoffs < 4 * RANGE) begin
            errors++;
            $display("FAIL R9 handoffs actual %0d expected at least %0d", handoffs, 4 * RANGE);
        end
        summary();
        $finish;
    end

endmodule